// File: doc/BRIEF.md
# Complementary Half-Bridge PWM with Dead-Band Insertion

This block generates a single pulse-width-modulated channel and presents it as a complementary pair of active-high outputs for a half-bridge power stage. A free-running cycle timer counts enabled ticks from zero up to a programmed period value and then restarts. The high-side output follows the nominal pulse, which is active while the timer is below the duty value. The low-side output follows the complement of that pulse.

Neither output turns on the moment its nominal signal rises. Each output has its own down-counter, loaded from a 7-bit dead-band setting, and it stays low until that count has run out. Both switches are therefore off for a guard interval around every transition. If an output's nominal window is no longer than the dead-band, that output produces no pulse at all in that period. Turn-off is never delayed.

The period, duty and dead-band settings are written through strobed ports into pending registers. They move into the working registers only at a period boundary, so a period never runs with a mix of old and new settings. The timer and both dead-band counters advance only on cycles where the tick enable is high.

Top module: `cpwm_halfbridge`

## Requirements
- R1: The cycle timer counts ticks from 0 up to the working period value P and then returns to 0, so one PWM period lasts P+1 ticks, and the high-side output rises once per period, P+1 ticks apart.
- R2: The nominal high-side pulse is active while the timer is below the working duty value; the nominal low-side signal is its exact complement. A duty of 0 gives no nominal high-side pulse, and a duty above P makes it active for the whole period.
- R3: After each nominal rise, an output stays low for exactly DB ticks, where DB is the working dead-band value. An output whose nominal window lasts N ticks is therefore high for N-DB ticks of the period when N > DB, and both outputs are low together for 2*DB ticks per period when both windows exceed DB.
- R4: An output whose nominal window is N ticks with N <= DB stays low for the whole of that window, so it produces no pulse in that period.
- R5: The two outputs are never high in the same cycle.
- R6: An output goes low on the same tick that its nominal signal goes low, with no delay; with DB = 0 the high-side output is high for exactly the duty count of ticks.
- R7: Values written to the period, duty or dead-band ports take effect only at the next period boundary, which is the tick on which the timer equals the working period; the period in progress completes with the old values.
- R8: While the tick enable is low, the timer, both dead-band counters and both outputs hold their values, even when the setting ports are written.
- R9: While reset is low at a clock edge, both outputs are driven low and the timer, the counters and all pending and working setting registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Cycle enable; the timer and dead-band counters step only when high |
| wr_period | input | 1 | Strobe that loads period_in into the pending period register |
| period_in | input | CNT_W | New period value P (period lasts P+1 ticks) |
| wr_duty | input | 1 | Strobe that loads duty_in into the pending duty register |
| duty_in | input | CNT_W | New duty value (ticks of nominal high-side pulse) |
| wr_dead | input | 1 | Strobe that loads dead_in into the pending dead-band register |
| dead_in | input | DEAD_W | New dead-band delay in ticks |
| out_hi | output | 1 | High-side drive, active-high, dead-band applied |
| out_lo | output | 1 | Low-side drive, active-high, dead-band applied |

## Verification
The bench measures how many ticks each output is high, and how many ticks both are low, over a full steady period. It does this for plain, delayed, suppressed, zero-duty and over-range-duty settings. A design that delays the falling edge, or that counts the dead-band from the wrong tick, gives high-time or guard-time totals that are off by the delay. A design that does not suppress short windows gives a nonzero count where zero is expected. A duty write made right after a high-side rise must leave that pulse at its old width; a design that applies settings at once would stretch it. The bench also holds the tick enable low across writes and applies reset in the middle of a pulse. A design with an ungated counter, or with asynchronous setting updates, would change its outputs while it should be holding them.

// File: rtl/cpwm_pkg.sv
// Package: shared constants and types for the complementary PWM block.
// Assumes: dead-band setting is 7 bits wide; two output channels exist.
package cpwm_pkg;

    localparam int DEAD_W_DEF = 7;
    localparam int N_CH       = 2;

    // Channel index: which nominal signal feeds which dead-band gate
    typedef enum logic [0:0] {
        CH_HIGH_SIDE = 1'b0,
        CH_LOW_SIDE  = 1'b1
    } cpwm_ch_e;

endpackage

// File: rtl/cpwm_setting_regs.sv
// Module: double-buffered period, duty and dead-band settings.
// Writes land in pending registers at once; the working registers copy the
// pending ones only when load_i is high (a period boundary).
// Assumes: strobes are single-cycle or level; the last value written wins.
module cpwm_setting_regs #(
    parameter int CNT_W  = 8,
    parameter int DEAD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              wr_period_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              wr_duty_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic              wr_dead_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic [CNT_W-1:0]  act_period_o,
    output logic [CNT_W-1:0]  act_duty_o,
    output logic [DEAD_W-1:0] act_dead_o
);

    logic [CNT_W-1:0]  pend_period_q;
    logic [CNT_W-1:0]  pend_duty_q;
    logic [DEAD_W-1:0] pend_dead_q;

    // Capture values from the write ports into the pending registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_period_q <= '0;
            pend_duty_q   <= '0;
            pend_dead_q   <= '0;
        end else begin
            if (wr_period_i) pend_period_q <= period_i;
            if (wr_duty_i)   pend_duty_q   <= duty_i;
            if (wr_dead_i)   pend_dead_q   <= dead_i;
        end
    end

    // Transfer the pending settings to the working set at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period_o <= '0;
            act_duty_o   <= '0;
            act_dead_o   <= '0;
        end else if (load_i) begin
            act_period_o <= pend_period_q;
            act_duty_o   <= pend_duty_q;
            act_dead_o   <= pend_dead_q;
        end
    end

endmodule

// File: rtl/cpwm_timebase.sv
// Module: free-running period timer and duty comparator.
// The timer steps once per tick from 0 to the working period value and then
// wraps. boundary_o marks the tick on which the wrap happens. nom_hi_o is the
// undelayed high-side pulse (timer below duty).
// Assumes: the working period changes only on a boundary, so the timer can
// never be above it.
module cpwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             boundary_o,
    output logic             nom_hi_o
);

    logic [CNT_W-1:0] timer_q;
    logic             at_end;

    // Detect the last tick of the period
    always_comb begin
        at_end     = (timer_q == period_i);
        boundary_o = tick_i && at_end;
    end

    // Advance the timer on each tick and wrap at the period value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (tick_i) begin
            if (at_end) timer_q <= '0;
            else        timer_q <= timer_q + 1'b1;
        end
    end

    // Nominal pulse: active while the timer is below the duty value
    always_comb begin
        nom_hi_o = (timer_q < duty_i);
    end

endmodule

// File: rtl/cpwm_deadband_gate.sv
// Module: dead-band gate for one output.
// Samples the nominal signal on each tick. A nominal rise loads a down-counter
// from the dead-band value, and the output stays low until the counter is
// zero. A nominal fall clears the counter and drops the output on that tick.
// Assumes: nom_i is stable between ticks; the output is registered so it is
// glitch-free.
module cpwm_deadband_gate #(
    parameter int DEAD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              nom_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              out_o
);

    logic              nom_q;
    logic [DEAD_W-1:0] wait_q;
    logic [DEAD_W-1:0] wait_nx;
    logic              out_nx;

    // Next value of the delay counter and of the output
    always_comb begin
        if (nom_i && !nom_q)  wait_nx = dead_i;
        else if (!nom_i)      wait_nx = '0;
        else if (wait_q != 0) wait_nx = wait_q - 1'b1;
        else                  wait_nx = wait_q;
        out_nx = nom_i && (wait_nx == 0);
    end

    // Update the edge detector, counter and output on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nom_q  <= 1'b0;
            wait_q <= '0;
            out_o  <= 1'b0;
        end else if (tick_i) begin
            nom_q  <= nom_i;
            wait_q <= wait_nx;
            out_o  <= out_nx;
        end
    end

endmodule

// File: rtl/cpwm_halfbridge.sv
// Module: complementary half-bridge PWM with dead-band, top level.
// Connects the setting registers, the timebase and one dead-band gate for each
// of the two outputs. The low-side nominal signal is the inverse of the
// high-side one.
// Assumes: synchronous active-low reset; tick is a one-clock enable pulse.
module cpwm_halfbridge #(
    parameter int CNT_W  = 8,
    parameter int DEAD_W = cpwm_pkg::DEAD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_period,
    input  logic [CNT_W-1:0]  period_in,
    input  logic              wr_duty,
    input  logic [CNT_W-1:0]  duty_in,
    input  logic              wr_dead,
    input  logic [DEAD_W-1:0] dead_in,
    output logic              out_hi,
    output logic              out_lo
);

    import cpwm_pkg::*;

    logic [CNT_W-1:0]  act_period;
    logic [CNT_W-1:0]  act_duty;
    logic [DEAD_W-1:0] act_dead;
    logic              boundary;
    logic              nom_hi;
    logic [N_CH-1:0]   nom_vec;
    logic [N_CH-1:0]   out_vec;

    cpwm_setting_regs #(
        .CNT_W  (CNT_W),
        .DEAD_W (DEAD_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (boundary),
        .wr_period_i  (wr_period),
        .period_i     (period_in),
        .wr_duty_i    (wr_duty),
        .duty_i       (duty_in),
        .wr_dead_i    (wr_dead),
        .dead_i       (dead_in),
        .act_period_o (act_period),
        .act_duty_o   (act_duty),
        .act_dead_o   (act_dead)
    );

    cpwm_timebase #(
        .CNT_W (CNT_W)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .period_i   (act_period),
        .duty_i     (act_duty),
        .boundary_o (boundary),
        .nom_hi_o   (nom_hi)
    );

    // Build the complementary nominal pair
    always_comb begin
        nom_vec[CH_HIGH_SIDE] = nom_hi;
        nom_vec[CH_LOW_SIDE]  = !nom_hi;
    end

    // One dead-band gate per output
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_gate
        cpwm_deadband_gate #(
            .DEAD_W (DEAD_W)
        ) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .nom_i  (nom_vec[ch]),
            .dead_i (act_dead),
            .out_o  (out_vec[ch])
        );
    end

    // Drive the output ports
    always_comb begin
        out_hi = out_vec[CH_HIGH_SIDE];
        out_lo = out_vec[CH_LOW_SIDE];
    end

endmodule

// File: rtl/cpwm_halfbridge_chk.sv
// Checker: temporal properties of the complementary PWM outputs.
// Bound to cpwm_halfbridge; observes ports and the nominal high-side pulse.
module cpwm_halfbridge_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic nom_hi,
    input logic out_hi,
    input logic out_lo
);

    logic rst_seen_q;

    // Remember that reset was low at the previous edge
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R9: outputs are low in the cycle after reset is sampled low
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            a_r9_reset_low : assert (!out_hi && !out_lo)
                else $error("R9: output high after reset");
        end
    end

    // R5: never both on
    a_r5_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hi && out_lo));

    // R6: high-side drops on the tick its nominal pulse is low
    a_r6_fast_off : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !nom_hi) |=> !out_hi);

    // R8: outputs hold while no tick
    a_r8_hold_hi : assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_hi));

    a_r8_hold_lo : assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_lo));

    // R3: the high side never turns on while its nominal pulse is absent
    a_r3_on_needs_nominal : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_hi) |-> $past(nom_hi));

endmodule

bind cpwm_halfbridge cpwm_halfbridge_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .nom_hi (nom_hi),
    .out_hi (out_hi),
    .out_lo (out_lo)
);

// File: tb/cpwm_halfbridge_tb.sv
`timescale 1ns/1ps
module cpwm_halfbridge_tb;

    localparam int CNT_W  = 8;
    localparam int DEAD_W = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tick;
    logic              wr_period;
    logic [CNT_W-1:0]  period_in;
    logic              wr_duty;
    logic [CNT_W-1:0]  duty_in;
    logic              wr_dead;
    logic [DEAD_W-1:0] dead_in;
    logic              out_hi;
    logic              out_lo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cpwm_halfbridge #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_period (wr_period),
        .period_in (period_in),
        .wr_duty   (wr_duty),
        .duty_in   (duty_in),
        .wr_dead   (wr_dead),
        .dead_in   (dead_in),
        .out_hi    (out_hi),
        .out_lo    (out_lo)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One tick pulse; returns at the negedge after it has been consumed
    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic write_cfg(input int p, input int d, input int db);
        @(negedge clk);
        wr_period = 1'b1; period_in = CNT_W'(p);
        wr_duty   = 1'b1; duty_in   = CNT_W'(d);
        wr_dead   = 1'b1; dead_in   = DEAD_W'(db);
        @(negedge clk);
        wr_period = 1'b0; wr_duty = 1'b0; wr_dead = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    // Count high ticks per output, both-low ticks and overlap over n ticks
    task automatic measure(input int n, output int c_hi, output int c_lo,
                           output int c_off, output int c_both);
        c_hi = 0; c_lo = 0; c_off = 0; c_both = 0;
        for (int i = 0; i < n; i++) begin
            do_tick();
            if (out_hi) c_hi++;
            if (out_lo) c_lo++;
            if (!out_hi && !out_lo) c_off++;
            if (out_hi && out_lo) c_both++;
        end
    endtask

    task automatic wait_hi_rise(output bit ok);
        bit prev = out_hi;
        ok = 1'b0;
        for (int i = 0; i < 600; i++) begin
            do_tick();
            if (!prev && out_hi) begin ok = 1'b1; break; end
            prev = out_hi;
        end
    endtask

    // Apply a setting, let it settle, measure one full period
    task automatic steady(input string req, input int p, input int d, input int db,
                          input int e_hi, input int e_lo, input int e_off);
        int c_hi, c_lo, c_off, c_both;
        write_cfg(p, d, db);
        run_ticks(4 * (p + 1) + 2 * db + 8);
        measure(p + 1, c_hi, c_lo, c_off, c_both);
        check({req, " high-side ticks"}, c_hi, e_hi);
        check({req, " low-side ticks"}, c_lo, e_lo);
        check({req, " both-low ticks"}, c_off, e_off);
        check("R5 overlap ticks", c_both, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 out_hi in reset", int'(out_hi), 0);
        check("R9 out_lo in reset", int'(out_lo), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 out_hi after release", int'(out_hi), 0);
        check("R9 out_lo after release", int'(out_lo), 0);
    endtask

    task automatic t_basic();
        // R2 R6: P=9, duty 4, no dead-band: 4 high, 6 low
        steady("R6", 9, 4, 0, 4, 6, 0);
        // R3: dead-band 2 trims both windows, 4 guard ticks
        steady("R3", 9, 4, 2, 2, 4, 4);
    endtask

    task automatic t_period();
        bit ok;
        int gap;
        write_cfg(5, 2, 1);
        run_ticks(30);
        wait_hi_rise(ok);
        check("R1 first rise found", int'(ok), 1);
        gap = 0;
        begin
            bit prev = out_hi;
            for (int i = 0; i < 40; i++) begin
                do_tick();
                gap++;
                if (!prev && out_hi) break;
                prev = out_hi;
            end
        end
        check("R1 rise spacing", gap, 6);
    endtask

    task automatic t_suppress();
        // R4: window 3 <= dead 5: no high-side pulse; low side 7-5=2
        steady("R4", 9, 3, 5, 0, 2, 8);
        // R4: dead 7 exceeds both windows (3 and 7)
        steady("R4 both", 9, 3, 7, 0, 0, 10);
    endtask

    task automatic t_extremes();
        // R2: duty 0, low side on for all ticks
        steady("R2 zero duty", 9, 0, 2, 0, 10, 0);
        // R2: duty above period, high side on for all ticks
        steady("R2 full duty", 9, 12, 3, 10, 0, 0);
    endtask

    task automatic t_buffer();
        bit ok;
        int run1, run2;
        write_cfg(9, 4, 0);
        run_ticks(30);
        wait_hi_rise(ok);
        check("R7 rise found", int'(ok), 1);
        @(negedge clk);
        wr_duty = 1'b1; duty_in = CNT_W'(7);
        @(negedge clk);
        wr_duty = 1'b0;
        run1 = 1;
        for (int i = 0; i < 20; i++) begin
            do_tick();
            if (!out_hi) break;
            run1++;
        end
        check("R7 pulse in progress keeps old duty", run1, 4);
        wait_hi_rise(ok);
        run2 = 1;
        for (int i = 0; i < 20; i++) begin
            do_tick();
            if (!out_hi) break;
            run2++;
        end
        check("R7 next pulse uses new duty", run2, 7);
    endtask

    task automatic t_hold();
        logic h, l;
        write_cfg(9, 4, 1);
        run_ticks(25);
        h = out_hi; l = out_lo;
        write_cfg(3, 1, 0);
        repeat (50) @(negedge clk);
        check("R8 out_hi held", int'(out_hi), int'(h));
        check("R8 out_lo held", int'(out_lo), int'(l));
    endtask

    task automatic t_reset_mid();
        bit ok;
        write_cfg(9, 6, 0);
        run_ticks(25);
        wait_hi_rise(ok);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R9 out_hi forced low", int'(out_hi), 0);
        check("R9 out_lo forced low", int'(out_lo), 0);
        rst_n = 1'b1;
        // Settings cleared: duty 0 period 0, so high side never turns on
        run_ticks(5);
        check("R9 settings cleared, out_hi", int'(out_hi), 0);
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0;
        wr_period = 1'b0; wr_duty = 1'b0; wr_dead = 1'b0;
        period_in = '0; duty_in = '0; dead_in = '0;
        t_reset();
        t_basic();
        t_period();
        t_suppress();
        t_extremes();
        t_buffer();
        t_hold();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule